// File: doc/BRIEF.md
# Byte Write Sequencer with Bit-7 Completion Polling

This block sits on the host side of a byte-wide, parallel-bus electrically erasable memory and performs one byte write per request. The host presents an address and a data byte. The sequencer drives the chip select, output enable, write strobe, address and write-data lines with programmable setup, pulse and hold widths. The write itself is carried out by the memory's internal timer after the write strobe returns high.

The memory does not report completion on a separate line. While its internal write runs, a read returns the inverse of the stored bit 7, and once the write has finished it returns the true value. After the strobe, the sequencer therefore issues a train of separate read cycles. It compares the returned most significant data bit with the same bit of the byte it wrote. A match ends the request with a one-cycle done pulse. If the elapsed time since the write strobe reaches the timeout limit before a match is seen, the request ends with a one-cycle error pulse. All widths and limits are given in clock cycles.

Top module: `eeprom_wrpoll_seq`

## Requirements
- R1: While reset is asserted and whenever the block is idle, `mem_ce_n_o`, `mem_oe_n_o` and `mem_we_n_o` are high, `mem_wdata_oe_o` is low, and `busy_o`, `done_o` and `err_o` are low.
- R2: A request (`req_i` high while `busy_o` is low) is taken at that clock edge. Its address and data are captured, and `busy_o` is high from the next cycle until the block returns to idle, including the done or error cycle.
- R3: The write phase has three parts, all with `mem_ce_n_o` low, `mem_oe_n_o` high and `mem_wdata_oe_o` high. First come SETUP_CYC cycles with `mem_we_n_o` high, then PULSE_CYC cycles with `mem_we_n_o` low, then HOLD_CYC cycles with `mem_we_n_o` high. Throughout, `mem_addr_o` and `mem_wdata_o` carry the captured address and data.
- R4: Each poll is a read cycle of ACCESS_CYC+1 clocks with `mem_ce_n_o` and `mem_oe_n_o` low, `mem_we_n_o` high and `mem_wdata_oe_o` low. `mem_rdata_i` is sampled at the end of its last clock.
- R5: After a sample that neither matches nor times out, `mem_ce_n_o` and `mem_oe_n_o` stay high for GAP_CYC cycles before the next poll.
- R6: If the sampled bit DATA_W-1 equals bit DATA_W-1 of the captured data, `done_o` is high for exactly the next cycle, and the block is then idle.
- R7: The elapsed count is 0 in the first cycle after `mem_we_n_o` rises and grows by one each cycle. If a sample does not match and the count at that sample is at least TIMEOUT_CYC, `err_o` is high for exactly the next cycle, and the block is then idle.
- R8: When a matching sample falls at or after the timeout limit, the result is done, not error.
- R9: `req_i` is ignored while `busy_o` is high. The captured address and data do not change, and no further write follows the current one.
- R10: `mem_we_n_o` is never low while `mem_oe_n_o` is low, and is low only with `mem_ce_n_o` low.
- R11: `mem_addr_o` keeps the captured write address through the whole request, including polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a byte write (taken only when idle) |
| req_addr_i | input | ADDR_W | Byte address of the write |
| req_data_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | High whenever the sequencer is not idle |
| done_o | output | 1 | One-cycle pulse: write confirmed by polling |
| err_o | output | 1 | One-cycle pulse: write not confirmed within timeout |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data toward the memory |
| mem_wdata_oe_o | output | 1 | Host drives the data bus when high |
| mem_rdata_i | input | DATA_W | Read data from the memory |

## Verification
The bit-7 match and the timeout expiry can both become true at the same poll sample. The bench provokes this by sweeping the memory model's internal write latency across the window between the last sample before the limit and the first sample at or past it. The latencies are chosen so that the true bit first appears exactly at a sample whose elapsed count is already at or beyond TIMEOUT_CYC. The reference model predicts done in that case. The bench requires the done pulse and the absence of an error pulse, and also confirms that at least one such late match was actually reached.

// File: rtl/wrpoll_pkg.sv
package wrpoll_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WE_PULSE,
      ST_HOLD,
      ST_POLL_ASSERT,
      ST_POLL_SAMPLE,
      ST_POLL_GAP,
      ST_DONE,
      ST_ERROR
   } seq_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wrpoll_phase_cnt.sv
module wrpoll_phase_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         last_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last_o = (cnt_q == '0);

endmodule

// File: rtl/wrpoll_elapsed.sv
module wrpoll_elapsed #(
   parameter int unsigned LIMIT = 625000,
   parameter int unsigned W     = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic expired_o
);

   localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

   logic [W-1:0] cnt_q;
   logic         at_limit;

   assign at_limit = (cnt_q >= LIMIT_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (run_i && !at_limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = at_limit;

endmodule

// File: rtl/eeprom_wrpoll_seq.sv
module eeprom_wrpoll_seq
   import wrpoll_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SETUP_CYC   = 2,
   parameter int unsigned PULSE_CYC   = 13,
   parameter int unsigned HOLD_CYC    = 2,
   parameter int unsigned ACCESS_CYC  = 5,
   parameter int unsigned GAP_CYC     = 1,
   parameter int unsigned TIMEOUT_CYC = 625000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              mem_ce_n_o,
   output logic              mem_oe_n_o,
   output logic              mem_we_n_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_wdata_oe_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);

   localparam int unsigned POLL_BIT = DATA_W - 1;
   localparam int unsigned LONGEST  = max2(max2(max2(SETUP_CYC, PULSE_CYC),
                                                max2(HOLD_CYC, ACCESS_CYC)), GAP_CYC);
   localparam int unsigned CNT_W    = (LONGEST > 1) ? $clog2(LONGEST) : 1;
   localparam int unsigned TO_W     = $clog2(TIMEOUT_CYC + 1);

   localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
   localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(GAP_CYC - 1);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("ADDR_W must be at least 1");
      end
      if (SETUP_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_write_cyc
         $error("write phase widths must each be at least one cycle");
      end
      if (ACCESS_CYC < 1) begin : g_bad_access
         $error("ACCESS_CYC must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1 so that polls stay separate reads");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 1");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              phase_last;
   logic              phase_load;
   logic [CNT_W-1:0]  phase_val;
   logic              to_expired;
   logic              to_clear;
   logic              to_run;
   logic              bit_match;

   assign bit_match = (mem_rdata_i[POLL_BIT] == data_q[POLL_BIT]);

   // state register and request capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_i) begin
            addr_q <= req_addr_i;
            data_q <= req_data_i;
         end
      end
   end

   // next state
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:        if (req_i)      state_d = ST_SETUP;
         ST_SETUP:       if (phase_last) state_d = ST_WE_PULSE;
         ST_WE_PULSE:    if (phase_last) state_d = ST_HOLD;
         ST_HOLD:        if (phase_last) state_d = ST_POLL_ASSERT;
         ST_POLL_ASSERT: if (phase_last) state_d = ST_POLL_SAMPLE;
         ST_POLL_SAMPLE: begin
            if (bit_match)       state_d = ST_DONE;
            else if (to_expired) state_d = ST_ERROR;
            else                 state_d = ST_POLL_GAP;
         end
         ST_POLL_GAP:    if (phase_last) state_d = ST_POLL_ASSERT;
         ST_DONE:        state_d = ST_IDLE;
         ST_ERROR:       state_d = ST_IDLE;
         default:        state_d = ST_IDLE;
      endcase
   end

   // phase width selection on every state change
   assign phase_load = (state_d != state_q);

   always_comb begin
      unique case (state_d)
         ST_SETUP:       phase_val = LD_SETUP;
         ST_WE_PULSE:    phase_val = LD_PULSE;
         ST_HOLD:        phase_val = LD_HOLD;
         ST_POLL_ASSERT: phase_val = LD_ACCESS;
         ST_POLL_GAP:    phase_val = LD_GAP;
         default:        phase_val = '0;
      endcase
   end

   wrpoll_phase_cnt #(
      .W (CNT_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (phase_load),
      .load_val_i (phase_val),
      .last_o     (phase_last)
   );

   // write-time budget: starts counting once the strobe has risen
   assign to_clear = (state_q == ST_WE_PULSE);
   assign to_run   = (state_q == ST_HOLD) || (state_q == ST_POLL_ASSERT) ||
                     (state_q == ST_POLL_SAMPLE) || (state_q == ST_POLL_GAP);

   wrpoll_elapsed #(
      .LIMIT (TIMEOUT_CYC),
      .W     (TO_W)
   ) u_elapsed (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (to_clear),
      .run_i     (to_run),
      .expired_o (to_expired)
   );

   // bus decode from state
   always_comb begin
      mem_ce_n_o     = 1'b1;
      mem_oe_n_o     = 1'b1;
      mem_we_n_o     = 1'b1;
      mem_wdata_oe_o = 1'b0;
      unique case (state_q)
         ST_SETUP, ST_HOLD: begin
            mem_ce_n_o     = 1'b0;
            mem_wdata_oe_o = 1'b1;
         end
         ST_WE_PULSE: begin
            mem_ce_n_o     = 1'b0;
            mem_we_n_o     = 1'b0;
            mem_wdata_oe_o = 1'b1;
         end
         ST_POLL_ASSERT, ST_POLL_SAMPLE: begin
            mem_ce_n_o = 1'b0;
            mem_oe_n_o = 1'b0;
         end
         default: ;
      endcase
   end

   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = data_q;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign err_o       = (state_q == ST_ERROR);

endmodule

// File: rtl/wrpoll_chk.sv
module wrpoll_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              mem_ce_n_o,
   input logic              mem_oe_n_o,
   input logic              mem_we_n_o,
   input logic              mem_wdata_oe_o,
   input logic [ADDR_W-1:0] mem_addr_o
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_wdata_oe_o && !done_o && !err_o));

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i) |=> busy_o);

   p_strobe_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> (!mem_ce_n_o && mem_wdata_oe_o));

   p_poll_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n_o |-> (!mem_ce_n_o && !mem_wdata_oe_o));

   p_gap_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n_o) |-> mem_ce_n_o);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (!err_o && !busy_o));

   p_busy_ignores_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && req_i && !done_o && !err_o) |=> busy_o);

   p_we_oe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n_o && !mem_oe_n_o));

   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

endmodule

bind eeprom_wrpoll_seq wrpoll_chk #(
   .ADDR_W (ADDR_W)
) u_wrpoll_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_i          (req_i),
   .busy_o         (busy_o),
   .done_o         (done_o),
   .err_o          (err_o),
   .mem_ce_n_o     (mem_ce_n_o),
   .mem_oe_n_o     (mem_oe_n_o),
   .mem_we_n_o     (mem_we_n_o),
   .mem_wdata_oe_o (mem_wdata_oe_o),
   .mem_addr_o     (mem_addr_o)
);

// File: tb/eeprom_wrpoll_seq_tb_top.sv
module eeprom_wrpoll_seq_tb_top;

   localparam int AW  = 12;
   localparam int DW  = 8;
   localparam int SU  = 2;
   localparam int PW  = 3;
   localparam int HD  = 1;
   localparam int ACC = 2;
   localparam int GAP = 2;
   localparam int TO  = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [AW-1:0] req_addr_i = '0;
   logic [DW-1:0] req_data_i = '0;
   logic          busy_o, done_o, err_o;
   logic          mem_ce_n_o, mem_oe_n_o, mem_we_n_o, mem_wdata_oe_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o;
   logic [DW-1:0] mem_rdata_i = '0;

   always #4 clk = ~clk;

   eeprom_wrpoll_seq #(
      .ADDR_W (AW), .DATA_W (DW), .SETUP_CYC (SU), .PULSE_CYC (PW),
      .HOLD_CYC (HD), .ACCESS_CYC (ACC), .GAP_CYC (GAP), .TIMEOUT_CYC (TO)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .req_i (req_i), .req_addr_i (req_addr_i),
      .req_data_i (req_data_i), .busy_o (busy_o), .done_o (done_o), .err_o (err_o),
      .mem_ce_n_o (mem_ce_n_o), .mem_oe_n_o (mem_oe_n_o), .mem_we_n_o (mem_we_n_o),
      .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
      .mem_wdata_oe_o (mem_wdata_oe_o), .mem_rdata_i (mem_rdata_i)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // reference model state: 0 idle,1 setup,2 strobe,3 hold,4 poll,5 sample,6 gap,7 done,8 error
   int          m_st = 0;
   int          m_cnt = 0;
   int          m_el = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;
   int          late_done = 0;

   // memory model
   int          mem_lat = 0;
   int          mem_left = 0;
   logic [DW-1:0] mem_byte = '0;
   logic        mem_prev_we = 1'b1;
   int          mem_writes = 0;

   int          seen_done = 0;
   int          seen_err = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic model_step();
      int old_st;
      int old_el;
      old_st = m_st;
      old_el = m_el;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_el = 0; m_addr = '0; m_data = '0;
         return;
      end
      if (old_st == 2) m_el = 0;
      else if (old_st >= 3 && old_st <= 6 && m_el < TO) m_el++;
      case (old_st)
         0: if (req_i) begin
               m_addr = req_addr_i; m_data = req_data_i; m_st = 1; m_cnt = SU - 1;
            end
         1: if (m_cnt == 0) begin m_st = 2; m_cnt = PW - 1; end else m_cnt--;
         2: if (m_cnt == 0) begin m_st = 3; m_cnt = HD - 1; end else m_cnt--;
         3: if (m_cnt == 0) begin m_st = 4; m_cnt = ACC - 1; end else m_cnt--;
         4: if (m_cnt == 0) m_st = 5; else m_cnt--;
         5: begin
               if (mem_rdata_i[DW-1] == m_data[DW-1]) begin
                  m_st = 7;
                  if (old_el >= TO) late_done++;
               end else if (old_el >= TO) m_st = 8;
               else begin m_st = 6; m_cnt = GAP - 1; end
            end
         6: if (m_cnt == 0) begin m_st = 4; m_cnt = ACC - 1; end else m_cnt--;
         default: m_st = 0;
      endcase
   endtask

   task automatic mem_step();
      if (mem_prev_we == 1'b0 && mem_we_n_o == 1'b1 && !mem_ce_n_o) begin
         mem_byte = mem_wdata_o;
         mem_left = mem_lat;
         mem_writes++;
      end else if (mem_left > 0) begin
         mem_left--;
      end
      mem_prev_we = mem_we_n_o;
      if (!mem_ce_n_o && !mem_oe_n_o)
         mem_rdata_i = (mem_left > 0) ? {~mem_byte[DW-1], mem_byte[DW-2:0]} : mem_byte;
      else
         mem_rdata_i = '0;
   endtask

   task automatic compare();
      logic e_ce, e_oe, e_we, e_oe_d;
      string tg;
      e_ce   = !(m_st >= 1 && m_st <= 5);
      e_oe   = !(m_st == 4 || m_st == 5);
      e_we   = !(m_st == 2);
      e_oe_d = (m_st >= 1 && m_st <= 3);
      if (m_st == 0 || m_st >= 7) tg = "R1";
      else if (m_st <= 3) tg = "R3";
      else if (m_st <= 5) tg = "R4";
      else tg = "R5";
      chk(mem_ce_n_o == e_ce, tg, "ce_n", 32'(mem_ce_n_o), 32'(e_ce));
      chk(mem_oe_n_o == e_oe, tg, "oe_n", 32'(mem_oe_n_o), 32'(e_oe));
      chk(mem_we_n_o == e_we, tg, "we_n", 32'(mem_we_n_o), 32'(e_we));
      chk(mem_wdata_oe_o == e_oe_d, tg, "wdata_oe", 32'(mem_wdata_oe_o), 32'(e_oe_d));
      chk(busy_o == (m_st != 0), "R2", "busy", 32'(busy_o), 32'(m_st != 0));
      chk(done_o == (m_st == 7), "R6", "done", 32'(done_o), 32'(m_st == 7));
      chk(err_o == (m_st == 8), "R7", "err", 32'(err_o), 32'(m_st == 8));
      chk(!(!mem_we_n_o && !mem_oe_n_o), "R10", "we/oe overlap", 32'(mem_we_n_o), 32'd1);
      if (m_st != 0)
         chk(mem_addr_o == m_addr, "R11", "addr", 32'(mem_addr_o), 32'(m_addr));
      if (mem_wdata_oe_o)
         chk(mem_wdata_o == m_data, "R3", "wdata", 32'(mem_wdata_o), 32'(m_data));
      if (done_o) seen_done++;
      if (err_o) seen_err++;
   endtask

   task automatic tick();
      @(negedge clk);
      model_step();
      mem_step();
      compare();
   endtask

   // expected outcome from the requirements: 1 = done, 0 = error
   function automatic bit predict_done(input int lat);
      int s;
      s = HD + ACC;
      forever begin
         if (s >= lat) return 1;
         if (s >= TO) return 0;
         s += ACC + 1 + GAP;
      end
   endfunction

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int lat, input bit poke_busy);
      int d0, e0, w0;
      bit exp_done;
      d0 = seen_done; e0 = seen_err; w0 = mem_writes;
      exp_done = predict_done(lat);
      mem_lat = lat;
      req_addr_i = a; req_data_i = d; req_i = 1'b1;
      tick();
      if (poke_busy) begin
         req_addr_i = ~a; req_data_i = ~d;
         repeat (5) tick();
      end
      req_i = 1'b0;
      for (int i = 0; i < 400; i++) begin
         tick();
         if (seen_done != d0 || seen_err != e0) break;
      end
      tick();
      chk(seen_done - d0 == int'(exp_done), exp_done ? "R6" : "R8", "done pulses",
          32'(seen_done - d0), 32'(exp_done));
      chk(seen_err - e0 == int'(!exp_done), "R7", "error pulses",
          32'(seen_err - e0), 32'(!exp_done));
      chk(mem_byte == d, "R3", "byte stored by memory model", 32'(mem_byte), 32'(d));
      chk(!busy_o, "R1", "idle after result", 32'(busy_o), 32'd0);
      if (poke_busy) begin
         repeat (4) tick();
         chk(!busy_o, "R9", "no write started by ignored request", 32'(busy_o), 32'd0);
         chk(mem_writes - w0 == 1, "R9", "write strobes", 32'(mem_writes - w0), 32'd1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
   end

   initial begin
      repeat (3) tick();
      chk(mem_ce_n_o && mem_oe_n_o && mem_we_n_o, "R1", "strobes in reset",
          32'({mem_ce_n_o, mem_oe_n_o, mem_we_n_o}), 32'h7);
      rst_n = 1'b1;
      repeat (2) tick();
      do_write(12'h123, 8'hA5, 0, 0);
      do_write(12'h7FF, 8'h3C, 10, 0);
      do_write(12'h0F0, 8'hC3, 7, 1);
      do_write(12'h001, 8'h80, 39, 0);
      do_write(12'hABC, 8'h00, 43, 0);
      do_write(12'h555, 8'hFF, 44, 0);
      do_write(12'h2AA, 8'h7F, 200, 0);
      do_write(12'h3E1, 8'h5A, 20, 0);
      chk(late_done >= 2, "R8", "late matches reached", 32'(late_done), 32'd2);
      report();
   end

endmodule